// File: doc/BRIEF.md
# Aging-Aware Bank Request Scheduler

This block sits in front of a banked non-volatile memory and decides, once per cycle, which queued request goes to the device next. A request to a bank that is still busy is never chosen. Among the rest, a request that has waited longer than a programmable backlog limit takes precedence, with the longest waiter winning. When no request is that late, the scheduler prefers the request whose bank has gone unused for the longest, so that idle periripheral circuits are put back to work and stop aging with nothing to show for it.

Before the chosen access is issued, the scheduler checks the health of the target bank. In aging mode, a bank is flagged for recovery when the external aging accumulator reports it past its aging limit or when its idle count exceeds a programmable idle limit. In fallback mode, with no aging information available, a bank is flagged once it has served a programmable number of accesses since its last recovery. A flagged bank receives a de-stress command instead of the access. The request stays in the queue and is chosen again once the bank is free. Each command marks its bank busy for a fixed number of cycles: one value for reads, one for writes, and a programmable value for de-stress. The queue storage, the device timing engine and the aging arithmetic are outside the block.

Top module: `aging_sched`

## Requirements
- R1: While reset is high, and in the first cycle after reset with an empty queue, `iss_valid` is 0, `iss_cmd` is 0 and `deq` is 0.
- R2: A request whose bank is busy is never selected. A bank is busy for RD_OCC cycles after a read is issued to it, for WR_OCC cycles after a write, and for max(ds_cycles, 2) cycles after a de-stress. The count starts at the clock edge that registers the command.
- R3: If any eligible request has a wait count strictly above `th_backlog`, the eligible request with the largest wait count is selected. Ties go to the lower queue slot.
- R4: Otherwise, the eligible request whose bank has the largest `bank_idle` value is selected. Ties go to the lower queue slot.
- R5: With `aging_mode`=1, a selected request whose bank has `bank_aged` set, or has `bank_idle` strictly above `th_idle`, produces a de-stress command (code 3) to that bank instead. `deq` stays 0 and the request remains queued.
- R6: With `aging_mode`=0, a selected request produces a de-stress command instead when its bank has served at least `ds_period` reads and writes since reset or since its last de-stress. `ds_period` must be at least 1.
- R7: Commands appear on the registered outputs one cycle after the inputs that caused them. The command codes are: 0 for none, 1 for read (`q_write`=0), 2 for write (`q_write`=1) and 3 for de-stress. A read or write pulses the `deq` bit of the chosen slot (bit i for slot i). The queue must clear that slot on the clock edge where `deq` is high.
- R8: A slot's wait count rises by one on each clock edge at which the slot is valid and is not being dequeued, saturating at 2^WAIT_W-1. The count is cleared when the slot is empty or when its request is dequeued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aging_mode | input | 1 | 1: use the threshold-based de-stress rule; 0: use the access-count rule |
| th_backlog | input | WAIT_W | Wait count above which a request is urgent |
| th_idle | input | IDLE_W | Idle count above which a bank is de-stressed |
| ds_period | input | CFG_W | Accesses per bank between de-stresses in fallback mode |
| ds_cycles | input | CFG_W | Busy time of a de-stress, in cycles |
| q_valid | input | QDEPTH | Slot holds a request |
| q_write | input | QDEPTH | Slot request is a write |
| q_bank | input | QDEPTH*BANK_W | Target bank per slot, slot i at bits [i*BANK_W +: BANK_W] |
| bank_idle | input | NBANK*IDLE_W | Idle cycles per bank since it last served |
| bank_aged | input | NBANK | Bank is past its aging limit |
| iss_valid | output | 1 | A command is issued this cycle |
| iss_cmd | output | 2 | Command code |
| iss_bank | output | BANK_W | Target bank of the command |
| deq | output | QDEPTH | One-hot dequeue of the issued slot |

## Verification
The hardest state to reach is the interplay of a deferred request with a busy bank. A de-stress must leave the request queued. The request must then wait out the de-stress occupancy while its wait count keeps rising. Once the bank frees, the request must re-enter selection, either through the idle ordering or as an urgent request. To reach this, the stimulus keeps the eight-slot queue near full against long write occupancies. It sets aging flags at random and lowers the idle and backlog limits in separate phases, so that de-stresses, starvation overrides and busy banks overlap often. A bench model tracks occupancy and wait counts from the requirements and predicts every cycle's command. A directed idle-count tie checks the slot ordering.

// File: rtl/aging_sched_pkg.sv
package aging_sched_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2,
        CMD_DS   = 2'd3
    } cmd_e;

    // shortest occupancy any command may impose on a bank
    localparam int unsigned MIN_OCC = 2;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/aging_sched_waits.sv
module aging_sched_waits #(
    parameter int QDEPTH = 8,
    parameter int WAIT_W = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [QDEPTH-1:0]          q_valid,
    input  logic [QDEPTH-1:0]          take,
    output logic [QDEPTH*WAIT_W-1:0]   waits
);
    localparam logic [WAIT_W-1:0] WMAX = '1;

    for (genvar i = 0; i < QDEPTH; i++) begin : g_slot
        logic [WAIT_W-1:0] cnt;
        always_ff @(posedge clk) begin
            if (rst || !q_valid[i] || take[i]) begin
                cnt <= '0;
            end else if (cnt != WMAX) begin
                cnt <= cnt + 1'b1;
            end
        end
        assign waits[i*WAIT_W +: WAIT_W] = cnt;
    end

endmodule

// File: rtl/aging_sched_banks.sv
module aging_sched_banks
    import aging_sched_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int CFG_W  = 10,
    parameter int RD_OCC = 57,
    parameter int WR_OCC = 210,
    localparam int BANK_W = $clog2(NBANK)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      issue_valid,
    input  cmd_e                      issue_cmd,
    input  logic [BANK_W-1:0]         issue_bank,
    input  logic [CFG_W-1:0]          ds_cycles,
    output logic [NBANK-1:0]          bank_free,
    output logic [NBANK*CFG_W-1:0]    served
);
    localparam int BIG   = max_of(RD_OCC, WR_OCC);
    localparam int OCC_W = max_of($clog2(BIG + 1), CFG_W) + 1;
    localparam logic [CFG_W-1:0] SMAX = '1;

    logic [OCC_W-1:0] load;

    always_comb begin
        case (issue_cmd)
            CMD_RD:  load = OCC_W'(RD_OCC);
            CMD_WR:  load = OCC_W'(WR_OCC);
            default: load = (ds_cycles < CFG_W'(MIN_OCC)) ? OCC_W'(MIN_OCC) : OCC_W'(ds_cycles);
        endcase
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic             hit;
        logic [OCC_W-1:0] busy;
        logic [CFG_W-1:0] uses;

        assign hit = issue_valid && (issue_bank == BANK_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                busy <= '0;
                uses <= '0;
            end else if (hit) begin
                busy <= load;
                if (issue_cmd == CMD_DS) begin
                    uses <= '0;
                end else if (uses != SMAX) begin
                    uses <= uses + 1'b1;
                end
            end else if (busy != '0) begin
                busy <= busy - 1'b1;
            end
        end

        assign bank_free[b] = (busy == '0);
        assign served[b*CFG_W +: CFG_W] = uses;
    end

endmodule

// File: rtl/aging_sched_pick.sv
module aging_sched_pick #(
    parameter int QDEPTH = 8,
    parameter int NBANK  = 8,
    parameter int WAIT_W = 10,
    parameter int IDLE_W = 16,
    localparam int BANK_W = $clog2(NBANK),
    localparam int SLOT_W = $clog2(QDEPTH)
) (
    input  logic [QDEPTH-1:0]         q_valid,
    input  logic [QDEPTH*BANK_W-1:0]  q_bank,
    input  logic [QDEPTH*WAIT_W-1:0]  waits,
    input  logic [NBANK-1:0]          bank_free,
    input  logic [NBANK*IDLE_W-1:0]   bank_idle,
    input  logic [WAIT_W-1:0]         th_backlog,
    output logic                      found,
    output logic [SLOT_W-1:0]         slot
);
    logic [BANK_W-1:0] qb_arr  [QDEPTH];
    logic [WAIT_W-1:0] w_arr   [QDEPTH];
    logic [IDLE_W-1:0] id_arr  [NBANK];

    for (genvar i = 0; i < QDEPTH; i++) begin : g_q
        assign qb_arr[i] = q_bank[i*BANK_W +: BANK_W];
        assign w_arr[i]  = waits[i*WAIT_W +: WAIT_W];
    end
    for (genvar b = 0; b < NBANK; b++) begin : g_b
        assign id_arr[b] = bank_idle[b*IDLE_W +: IDLE_W];
    end

    logic              crit_hit, norm_hit;
    logic [SLOT_W-1:0] crit_slot, norm_slot;
    logic [WAIT_W-1:0] crit_wait;
    logic [IDLE_W-1:0] norm_idle;

    always_comb begin
        crit_hit  = 1'b0;
        crit_slot = '0;
        crit_wait = '0;
        norm_hit  = 1'b0;
        norm_slot = '0;
        norm_idle = '0;
        for (int i = 0; i < QDEPTH; i++) begin
            if (q_valid[i] && bank_free[qb_arr[i]]) begin
                // strict compares keep the lower slot on ties
                if ((w_arr[i] > th_backlog) && (!crit_hit || (w_arr[i] > crit_wait))) begin
                    crit_hit  = 1'b1;
                    crit_slot = SLOT_W'(i);
                    crit_wait = w_arr[i];
                end
                if (!norm_hit || (id_arr[qb_arr[i]] > norm_idle)) begin
                    norm_hit  = 1'b1;
                    norm_slot = SLOT_W'(i);
                    norm_idle = id_arr[qb_arr[i]];
                end
            end
        end
        found = crit_hit || norm_hit;
        slot  = crit_hit ? crit_slot : norm_slot;
    end

endmodule

// File: rtl/aging_sched.sv
module aging_sched
    import aging_sched_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int QDEPTH = 8,
    parameter int WAIT_W = 10,
    parameter int IDLE_W = 16,
    parameter int CFG_W  = 10,
    parameter int RD_OCC = 57,
    parameter int WR_OCC = 210,
    localparam int BANK_W = $clog2(NBANK),
    localparam int SLOT_W = $clog2(QDEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      aging_mode,
    input  logic [WAIT_W-1:0]         th_backlog,
    input  logic [IDLE_W-1:0]         th_idle,
    input  logic [CFG_W-1:0]          ds_period,
    input  logic [CFG_W-1:0]          ds_cycles,
    input  logic [QDEPTH-1:0]         q_valid,
    input  logic [QDEPTH-1:0]         q_write,
    input  logic [QDEPTH*BANK_W-1:0]  q_bank,
    input  logic [NBANK*IDLE_W-1:0]   bank_idle,
    input  logic [NBANK-1:0]          bank_aged,
    output logic                      iss_valid,
    output logic [1:0]                iss_cmd,
    output logic [BANK_W-1:0]         iss_bank,
    output logic [QDEPTH-1:0]         deq
);
    logic [QDEPTH*WAIT_W-1:0] waits;
    logic [NBANK-1:0]         bank_free;
    logic [NBANK*CFG_W-1:0]   served;
    logic                     pick_found;
    logic [SLOT_W-1:0]        pick_slot;

    logic                     nxt_valid;
    cmd_e                     nxt_cmd;
    logic [BANK_W-1:0]        nxt_bank;
    logic [QDEPTH-1:0]        nxt_take;
    logic                     need_ds;
    logic [IDLE_W-1:0]        tgt_idle;
    logic [CFG_W-1:0]         tgt_served;
    cmd_e                     cmd_q;

    aging_sched_waits #(.QDEPTH(QDEPTH), .WAIT_W(WAIT_W)) u_waits (
        .clk(clk), .rst(rst), .q_valid(q_valid), .take(nxt_take), .waits(waits)
    );

    aging_sched_banks #(.NBANK(NBANK), .CFG_W(CFG_W), .RD_OCC(RD_OCC), .WR_OCC(WR_OCC)) u_banks (
        .clk(clk), .rst(rst), .issue_valid(nxt_valid), .issue_cmd(nxt_cmd),
        .issue_bank(nxt_bank), .ds_cycles(ds_cycles), .bank_free(bank_free), .served(served)
    );

    aging_sched_pick #(.QDEPTH(QDEPTH), .NBANK(NBANK), .WAIT_W(WAIT_W), .IDLE_W(IDLE_W)) u_pick (
        .q_valid(q_valid), .q_bank(q_bank), .waits(waits), .bank_free(bank_free),
        .bank_idle(bank_idle), .th_backlog(th_backlog), .found(pick_found), .slot(pick_slot)
    );

    always_comb begin
        nxt_bank   = q_bank[pick_slot*BANK_W +: BANK_W];
        tgt_idle   = bank_idle[nxt_bank*IDLE_W +: IDLE_W];
        tgt_served = served[nxt_bank*CFG_W +: CFG_W];
        if (aging_mode) begin
            need_ds = bank_aged[nxt_bank] || (tgt_idle > th_idle);
        end else begin
            need_ds = (tgt_served >= ds_period);
        end
        nxt_valid = pick_found;
        if (!pick_found) begin
            nxt_cmd = CMD_NONE;
        end else if (need_ds) begin
            nxt_cmd = CMD_DS;
        end else begin
            nxt_cmd = q_write[pick_slot] ? CMD_WR : CMD_RD;
        end
        nxt_take = (pick_found && !need_ds) ? (QDEPTH'(1) << pick_slot) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            iss_valid <= 1'b0;
            cmd_q     <= CMD_NONE;
            iss_bank  <= '0;
            deq       <= '0;
        end else begin
            iss_valid <= nxt_valid;
            cmd_q     <= nxt_cmd;
            iss_bank  <= nxt_valid ? nxt_bank : '0;
            deq       <= nxt_take;
        end
    end

    assign iss_cmd = cmd_q;

endmodule

// File: rtl/aging_sched_chk.sv
module aging_sched_chk
    import aging_sched_pkg::*;
#(
    parameter int NBANK  = 8,
    parameter int QDEPTH = 8,
    localparam int BANK_W = $clog2(NBANK)
) (
    input logic              clk,
    input logic              rst,
    input logic              iss_valid,
    input logic [1:0]        iss_cmd,
    input logic [BANK_W-1:0] iss_bank,
    input logic [QDEPTH-1:0] deq
);
    // R7
    deq_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(deq));

    // R7
    deq_with_access_chk: assert property (@(posedge clk) disable iff (rst)
        (deq != '0) |-> (iss_valid && (iss_cmd == CMD_RD || iss_cmd == CMD_WR)));

    // R5
    ds_keeps_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_cmd == CMD_DS) |-> (deq == '0));

    // R2
    bank_gap_chk: assert property (@(posedge clk) disable iff (rst)
        iss_valid |=> !(iss_valid && (iss_bank == $past(iss_bank))));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !iss_valid |-> (deq == '0));

endmodule

bind aging_sched aging_sched_chk #(.NBANK(NBANK), .QDEPTH(QDEPTH)) u_chk (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_cmd(iss_cmd),
    .iss_bank(iss_bank), .deq(deq)
);

// File: tb/test_aging_sched.sv
module test_aging_sched;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;
    localparam int Q = 8;
    localparam int BW = 3;
    localparam int WAIT_W = 10;
    localparam int IDLE_W = 16;
    localparam int CFG_W = 10;
    localparam int RD_OCC = 57;
    localparam int WR_OCC = 210;
    localparam int WMAX = (1 << WAIT_W) - 1;
    localparam int IMAX = (1 << IDLE_W) - 1;
    localparam int SMAX = (1 << CFG_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic aging_mode = 1'b1;
    logic [WAIT_W-1:0] th_backlog = '1;
    logic [IDLE_W-1:0] th_idle = '1;
    logic [CFG_W-1:0] ds_period = 10'd100;
    logic [CFG_W-1:0] ds_cycles = 10'd20;
    logic [Q-1:0] q_valid = '0;
    logic [Q-1:0] q_write = '0;
    logic [Q*BW-1:0] q_bank = '0;
    logic [NB*IDLE_W-1:0] bank_idle = '0;
    logic [NB-1:0] bank_aged = '0;
    logic iss_valid;
    logic [1:0] iss_cmd;
    logic [BW-1:0] iss_bank;
    logic [Q-1:0] deq;

    always #(CLK_PERIOD/2) clk = ~clk;

    aging_sched #(.NBANK(NB), .QDEPTH(Q), .WAIT_W(WAIT_W), .IDLE_W(IDLE_W), .CFG_W(CFG_W),
                  .RD_OCC(RD_OCC), .WR_OCC(WR_OCC)) i_aging_sched (
        .clk(clk), .rst(rst), .aging_mode(aging_mode), .th_backlog(th_backlog),
        .th_idle(th_idle), .ds_period(ds_period), .ds_cycles(ds_cycles),
        .q_valid(q_valid), .q_write(q_write), .q_bank(q_bank), .bank_idle(bank_idle),
        .bank_aged(bank_aged), .iss_valid(iss_valid), .iss_cmd(iss_cmd),
        .iss_bank(iss_bank), .deq(deq)
    );

    int checks = 0;
    int errors = 0;

    // bench model state
    bit qv[Q];
    bit qw[Q];
    int qb[Q];
    int waitc[Q];
    int idle[NB];
    bit aged[NB];
    int busy[NB];
    int served[NB];

    bit e_valid = 0;
    int e_cmd = 0;
    int e_bank = 0;
    int e_slot = 0;
    bit e_take = 0;
    string e_tag = "R1";

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic drive();
        for (int i = 0; i < Q; i++) begin
            q_valid[i] = qv[i];
            q_write[i] = qw[i];
            q_bank[i*BW +: BW] = BW'(qb[i]);
        end
        for (int b = 0; b < NB; b++) begin
            bank_idle[b*IDLE_W +: IDLE_W] = IDLE_W'(idle[b]);
            bank_aged[b] = aged[b];
        end
    endtask

    function automatic int ds_occ();
        return (int'(ds_cycles) < 2) ? 2 : int'(ds_cycles);
    endfunction

    task automatic compute_exp();
        int cs = -1;
        int cw = 0;
        int ns = -1;
        int ni = 0;
        int sel;
        bit ds;
        for (int i = 0; i < Q; i++) begin
            if (qv[i] && busy[qb[i]] == 0) begin
                if (waitc[i] > int'(th_backlog) && (cs < 0 || waitc[i] > cw)) begin
                    cs = i;
                    cw = waitc[i];
                end
                if (ns < 0 || idle[qb[i]] > ni) begin
                    ns = i;
                    ni = idle[qb[i]];
                end
            end
        end
        sel = (cs >= 0) ? cs : ns;
        if (sel < 0) begin
            e_valid = 0; e_cmd = 0; e_bank = 0; e_slot = 0; e_take = 0;
            e_tag = "R2,R7";
        end else begin
            e_valid = 1;
            e_slot = sel;
            e_bank = qb[sel];
            if (aging_mode)
                ds = aged[e_bank] || (idle[e_bank] > int'(th_idle));
            else
                ds = served[e_bank] >= int'(ds_period);
            e_cmd = ds ? 3 : (qw[sel] ? 2 : 1);
            e_take = !ds;
            if (ds) e_tag = aging_mode ? "R5,R7" : "R6,R7";
            else if (cs >= 0) e_tag = "R3,R8,R7";
            else e_tag = "R4,R7";
        end
    endtask

    // compare outputs, then advance the model across the clock edge just taken
    task automatic advance();
        int exp_deq;
        exp_deq = e_take ? (1 << e_slot) : 0;
        check(iss_valid == e_valid, e_tag, int'(iss_valid), int'(e_valid));
        check(int'(iss_cmd) == e_cmd, e_tag, int'(iss_cmd), e_cmd);
        if (e_valid) check(int'(iss_bank) == e_bank, e_tag, int'(iss_bank), e_bank);
        check(int'(deq) == exp_deq, e_tag, int'(deq), exp_deq);
        for (int b = 0; b < NB; b++) begin
            if (e_valid && e_bank == b) begin
                busy[b] = (e_cmd == 1) ? RD_OCC : (e_cmd == 2) ? WR_OCC : ds_occ();
                if (e_cmd == 3) served[b] = 0;
                else if (served[b] < SMAX) served[b]++;
            end else if (busy[b] > 0) begin
                busy[b]--;
            end
        end
        for (int i = 0; i < Q; i++) begin
            if (!qv[i] || (e_take && e_slot == i)) waitc[i] = 0;
            else if (waitc[i] < WMAX) waitc[i]++;
        end
        if (e_take) qv[e_slot] = 0;
        for (int b = 0; b < NB; b++) begin
            if (e_valid && e_bank == b) idle[b] = 0;
            else if (idle[b] < IMAX) idle[b]++;
            if (e_valid && e_cmd == 3 && e_bank == b) aged[b] = 0;
        end
    endtask

    task automatic finish_cycle();
        drive();
        compute_exp();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic random_inputs(input int fill_mod);
        for (int i = 0; i < Q; i++) begin
            if (!qv[i] && fill_mod > 0 && ($urandom % fill_mod) == 0) begin
                qv[i] = 1;
                qw[i] = bit'($urandom % 2);
                qb[i] = int'($urandom % NB);
            end
        end
        for (int b = 0; b < NB; b++)
            if (($urandom % 600) == 0) aged[b] = 1;
    endtask

    task automatic run_random(input int n, input int fill_mod);
        for (int k = 0; k < n; k++) begin
            advance();
            random_inputs(fill_mod);
            finish_cycle();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < Q; i++) begin qv[i] = 0; qw[i] = 0; qb[i] = 0; waitc[i] = 0; end
        for (int b = 0; b < NB; b++) begin idle[b] = 0; aged[b] = 0; busy[b] = 0; served[b] = 0; end
        drive();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs quiet during reset
        check(iss_valid == 1'b0, "R1", int'(iss_valid), 0);
        check(iss_cmd == 2'd0, "R1", int'(iss_cmd), 0);
        check(deq == '0, "R1", int'(deq), 0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R1: first cycle after reset with an empty queue
        check(iss_valid == 1'b0, "R1", int'(iss_valid), 0);
        check(deq == '0, "R1", int'(deq), 0);

        // directed R4 tie: banks 2 and 3 share the top idle count, slot 1 must win
        advance();
        qv[0] = 1; qw[0] = 0; qb[0] = 1;
        qv[1] = 1; qw[1] = 0; qb[1] = 2;
        qv[2] = 1; qw[2] = 1; qb[2] = 3;
        idle[1] = 10; idle[2] = 50; idle[3] = 50;
        finish_cycle();
        check(deq == 8'b0000_0010, "R4", int'(deq), 2);
        run_random(6, 0);

        // aging mode, moderate limits
        th_backlog = 10'd400;
        th_idle = 16'd300;
        ds_cycles = 10'd20;
        run_random(4000, 4);

        // fallback counting mode
        aging_mode = 1'b0;
        ds_period = 10'd3;
        ds_cycles = 10'd1;
        run_random(3000, 4);

        // tight backlog limit, idle rule off
        aging_mode = 1'b1;
        th_backlog = 10'd20;
        th_idle = '1;
        ds_cycles = 10'd30;
        run_random(3000, 3);

        // drain
        run_random(500, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule